// File: doc/BRIEF.md
# Dual-Edge Read Strobe Sequencer for a Burst-of-Two QDR SRAM

This block produces the control strobes for one read of a burst-of-two quad-data-rate SRAM. When a read request is seen, it drives the active-low read-port select and an address enable for one cycle. After the device read latency, it raises a capture enable for each of the two returned beats and a one-cycle data-valid pulse. Latency is fixed at build time to either 2.0 or 2.5 clock cycles. Because the beats arrive half a cycle apart, two small machines do the work. One runs on the rising edge of the master clock and one on the falling edge. A single-cycle handoff flag links them.

Rising-edge machine states: `RS_IDLE`, `RS_SEL`, `RS_WAIT1`, `RS_WAIT2`, `RS_BEAT`. Its transitions are:
- IDLE goes to SEL when the request is high.
- SEL goes to WAIT1.
- WAIT1 goes to WAIT2 at 2.5 latency, or to BEAT at 2.0 latency.
- WAIT2 goes to BEAT.
- BEAT goes back to IDLE.

The flag is raised in WAIT2 at 2.5 latency and in BEAT at 2.0 latency. Falling-edge machine states: `FS_IDLE` and `FS_ACT`. FS_IDLE goes to FS_ACT on a falling edge that sees the flag. FS_ACT goes back to FS_IDLE on the next falling edge.

At 2.5 latency, FS_ACT drives beat 0 capture, and RS_BEAT drives beat 1 capture and valid. At 2.0 latency the roles swap: RS_BEAT drives beat 0 capture, and FS_ACT drives beat 1 capture and valid.

Top module: `qdr_rd_seq`

## Requirements
- R1: After reset, and whenever no read is in progress, rd_sel_n is 1 and rd_addr_en, beat0_cap_en, beat1_cap_en and rd_valid are 0.
- R2: A rising edge that samples rd_req=1 while idle ("command edge", time 0) drives rd_sel_n=0 and rd_addr_en=1 for exactly the following clock period (0 to 1.0).
- R3: With LAT_HALF_CYCLE=1, beat0_cap_en is 1 from the falling edge at 2.5 to the falling edge at 3.5, and beat1_cap_en is 1 from 3.0 to 4.0.
- R4: With LAT_HALF_CYCLE=0, beat0_cap_en is 1 from 2.0 to 3.0, and beat1_cap_en is 1 from 2.5 to 3.5.
- R5: rd_valid is a single one-period pulse that coincides exactly with beat1_cap_en.
- R6: rd_req is ignored while a read is in progress. With rd_req held at 1, the next command edge is at 5 cycles for 2.5 latency and at 4 cycles for 2.0 latency.
- R7: Each read produces exactly one falling-edge action: the flag lasts one cycle, and FS_ACT lasts one period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; both edges used |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request, sampled on rising edges in idle |
| rd_sel_n | output | 1 | Active-low read-port select |
| rd_addr_en | output | 1 | Read address output enable |
| beat0_cap_en | output | 1 | Capture enable for first read beat |
| beat1_cap_en | output | 1 | Capture enable for second read beat |
| rd_valid | output | 1 | One-period pulse when the burst is complete |

## Verification
The outputs are decoded directly from state. Each result is therefore due a whole number of half-periods after the command edge:
- select and address enable are due at half-periods 0 and 1;
- capture and valid windows start at half-period 4, 5 or 6, depending on the latency.

The bench drives one request into two instances, one at each latency. It then samples every output a quarter period after each clock edge for ten half-periods and compares against the window table taken from the requirements. Hold-off is checked by sampling the select once per cycle, a quarter period after each rising edge, under a held request and under a request pulse that lands during the wait states.

// File: rtl/qdr_rd_pkg.sv
package qdr_rd_pkg;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_SEL,
        RS_WAIT1,
        RS_WAIT2,
        RS_BEAT
    } rise_st_t;

    typedef enum logic {
        FS_IDLE,
        FS_ACT
    } fall_st_t;

endpackage

// File: rtl/qdr_rd_rise_fsm.sv
module qdr_rd_rise_fsm
    import qdr_rd_pkg::*;
#(
    parameter bit LAT_HALF_CYCLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    output logic sel_n,
    output logic addr_en,
    output logic beat_en,
    output logic handoff
);

    rise_st_t state_q;
    rise_st_t state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE:  state_d = rd_req ? RS_SEL : RS_IDLE;
            RS_SEL:   state_d = RS_WAIT1;
            RS_WAIT1: state_d = LAT_HALF_CYCLE ? RS_WAIT2 : RS_BEAT;
            RS_WAIT2: state_d = RS_BEAT;
            RS_BEAT:  state_d = RS_IDLE;
            default:  state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output decode
    always_comb begin
        sel_n   = 1'b1;
        addr_en = 1'b0;
        beat_en = 1'b0;
        handoff = 1'b0;
        unique case (state_q)
            RS_IDLE:  ;
            RS_SEL: begin
                sel_n   = 1'b0;
                addr_en = 1'b1;
            end
            RS_WAIT1: ;
            RS_WAIT2: handoff = LAT_HALF_CYCLE;
            RS_BEAT: begin
                beat_en = 1'b1;
                handoff = !LAT_HALF_CYCLE;
            end
            default:  ;
        endcase
    end

    // R2: select is asserted for one cycle per command
    a_r2_sel_single: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_n |=> sel_n);

    // R6: a request in a busy state never starts a command at the next edge
    a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && state_q != RS_IDLE) |=> sel_n);

    // R7: handoff flag is a single-cycle pulse
    a_r7_flag_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        handoff |=> !handoff);

endmodule

// File: rtl/qdr_rd_fall_fsm.sv
module qdr_rd_fall_fsm
    import qdr_rd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic handoff,
    output logic act_en
);

    fall_st_t state_q;
    fall_st_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE: state_d = handoff ? FS_ACT : FS_IDLE;
            FS_ACT:  state_d = FS_IDLE;
            default: state_d = FS_IDLE;
        endcase
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        act_en = 1'b0;
        unique case (state_q)
            FS_IDLE: act_en = 1'b0;
            FS_ACT:  act_en = 1'b1;
            default: act_en = 1'b0;
        endcase
    end

    // R7: the flag seen at a falling edge produces the action
    a_r7_flag_to_act: assert property (@(negedge clk) disable iff (!rst_n)
        handoff |=> act_en);

    // R7: the action lasts exactly one period
    a_r7_act_once: assert property (@(negedge clk) disable iff (!rst_n)
        act_en |=> !act_en);

endmodule

// File: rtl/qdr_rd_seq.sv
module qdr_rd_seq #(
    parameter bit LAT_HALF_CYCLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    output logic rd_sel_n,
    output logic rd_addr_en,
    output logic beat0_cap_en,
    output logic beat1_cap_en,
    output logic rd_valid
);

    logic rise_beat;
    logic handoff;
    logic fall_act;

    qdr_rd_rise_fsm #(
        .LAT_HALF_CYCLE(LAT_HALF_CYCLE)
    ) u_rise (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (rd_req),
        .sel_n   (rd_sel_n),
        .addr_en (rd_addr_en),
        .beat_en (rise_beat),
        .handoff (handoff)
    );

    qdr_rd_fall_fsm u_fall (
        .clk     (clk),
        .rst_n   (rst_n),
        .handoff (handoff),
        .act_en  (fall_act)
    );

    // latency option picks which edge domain owns each beat
    generate
        if (LAT_HALF_CYCLE) begin : g_lat_2p5
            assign beat0_cap_en = fall_act;
            assign beat1_cap_en = rise_beat;
            assign rd_valid     = rise_beat;
        end else begin : g_lat_2p0
            assign beat0_cap_en = rise_beat;
            assign beat1_cap_en = fall_act;
            assign rd_valid     = fall_act;
        end
    endgenerate

    // R1: no capture while the command is on the bus
    a_r1_sel_no_cap: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_sel_n |-> (!beat0_cap_en && !beat1_cap_en && !rd_valid));

    // R5: valid only together with the second-beat enable
    a_r5_valid_with_beat1: assert property (@(negedge clk) disable iff (!rst_n)
        rd_valid |-> beat1_cap_en);

endmodule

// File: tb/qdr_rd_seq_tb_top.sv
module qdr_rd_seq_tb_top;

    localparam time CLK_PERIOD = 8;
    localparam time HALF = CLK_PERIOD / 2;
    localparam time QTR  = CLK_PERIOD / 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_req = 1'b0;

    logic a_sel_n, a_addr, a_b0, a_b1, a_val;
    logic b_sel_n, b_addr, b_b0, b_b1, b_val;

    int n_checks = 0;
    int n_fails  = 0;

    always #(HALF) clk = ~clk;

    // 2.5-cycle latency
    qdr_rd_seq #(.LAT_HALF_CYCLE(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req),
        .rd_sel_n(a_sel_n), .rd_addr_en(a_addr),
        .beat0_cap_en(a_b0), .beat1_cap_en(a_b1), .rd_valid(a_val)
    );

    // 2.0-cycle latency
    qdr_rd_seq #(.LAT_HALF_CYCLE(1'b0)) dut_i_int (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req),
        .rd_sel_n(b_sel_n), .rd_addr_en(b_addr),
        .beat0_cap_en(b_b0), .beat1_cap_en(b_b1), .rd_valid(b_val)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // R1: reset and idle outputs
    task automatic test_reset();
        rst_n  = 1'b0;
        rd_req = 1'b0;
        #(CLK_PERIOD * 2 + QTR);
        chk("R1 reset sel_n A", a_sel_n, 1'b1);
        chk("R1 reset sel_n B", b_sel_n, 1'b1);
        chk("R1 reset caps A", a_addr | a_b0 | a_b1 | a_val, 1'b0);
        chk("R1 reset caps B", b_addr | b_b0 | b_b1 | b_val, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(posedge clk);
            #(QTR);
            chk("R1 idle sel_n A", a_sel_n, 1'b1);
            chk("R1 idle sel_n B", b_sel_n, 1'b1);
            chk("R1 idle outs A", a_addr | a_b0 | a_b1 | a_val, 1'b0);
            chk("R1 idle outs B", b_addr | b_b0 | b_b1 | b_val, 1'b0);
        end
    endtask

    // R2 R3 R4 R5 R7: one read, checked per half period
    task automatic test_single_read();
        @(negedge clk);
        rd_req = 1'b1;
        @(posedge clk);
        #(QTR);
        rd_req = 1'b0;
        for (int h = 0; h < 10; h++) begin
            chk("R2 sel_n A", a_sel_n, !(h < 2));
            chk("R2 addr_en A", a_addr, (h < 2));
            chk("R2 sel_n B", b_sel_n, !(h < 2));
            chk("R2 addr_en B", b_addr, (h < 2));
            chk("R3 beat0 2.5", a_b0, (h == 5 || h == 6));
            chk("R3 beat1 2.5", a_b1, (h == 6 || h == 7));
            chk("R5 valid 2.5", a_val, (h == 6 || h == 7));
            chk("R4 beat0 2.0", b_b0, (h == 4 || h == 5));
            chk("R4 beat1 2.0", b_b1, (h == 5 || h == 6));
            chk("R5 valid 2.0", b_val, (h == 5 || h == 6));
            #(HALF);
        end
    endtask

    // R6: held request gives back-to-back commands at the latency-dependent spacing
    task automatic test_held_req();
        @(negedge clk);
        rd_req = 1'b1;
        @(posedge clk);
        #(QTR);
        for (int c = 0; c < 12; c++) begin
            chk("R6 held sel_n 2.5", a_sel_n, !(c % 5 == 0));
            chk("R6 held sel_n 2.0", b_sel_n, !(c % 4 == 0));
            if (c == 11) rd_req = 1'b0;
            #(CLK_PERIOD);
        end
        #(CLK_PERIOD * 6);
    endtask

    // R6: request pulse during wait states is dropped
    task automatic test_busy_pulse();
        @(negedge clk);
        rd_req = 1'b1;
        @(posedge clk);
        #(QTR);
        rd_req = 1'b0;
        for (int c = 0; c < 8; c++) begin
            if (c == 1) rd_req = 1'b1;
            if (c == 2) rd_req = 1'b0;
            chk("R6 busy sel_n 2.5", a_sel_n, !(c == 0));
            chk("R6 busy sel_n 2.0", b_sel_n, !(c == 0));
            #(CLK_PERIOD);
        end
        chk("R1 idle after read A", a_b0 | a_b1 | a_val, 1'b0);
        chk("R1 idle after read B", b_b0 | b_b1 | b_val, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        test_reset();
        test_single_read();
        test_held_req();
        test_busy_pulse();
        test_single_read();
        summary();
    end

endmodule